// File: doc/BRIEF.md
# Banked Data Pointer and Memory Router

This block keeps several wide data pointers (two 16-bit ones by default) behind a byte-wide special-function-register bus. Every byte of every pointer has its own register address and can be read or written at any time. One bank-select input names the pointer that feeds indirect data-memory accesses. The increment strobe advances only that pointer.

Each indirect access is sent to one of two places. A routing input sends it either to an on-chip nonvolatile data memory port or to an external data memory port. The internal port takes the low address bits of the active pointer. The external port takes the pointer's full value. Writes to the on-chip memory must pass a gate: the memory write-enable input must be set, and the memory must not report busy. A write that fails the gate issues no request and raises a one-cycle refusal flag.

The port outputs are registered by default, so a request shows up on the ports in the cycle after it is sampled. A parameter can select a pass-through port stage instead.

Top module: `dptr_unit`

## Requirements
- R1: After reset every pointer bank holds 0000H, so all of its register bytes read as 00H.
- R2: Bank 0 low/high bytes are at register addresses 82H/83H and bank 1 low/high bytes at 84H/85H (bank b byte k at 82H + 2b + k); each is readable and writable whatever the bank select value.
- R3: With bank_sel = 0 the access address comes from bank 0, with bank_sel = 1 from bank 1.
- R4: With int_en = 1 an access goes to the internal port with the low IADDR_W pointer bits as address; with int_en = 0 it goes to the external port with the full pointer value, and external writes are never gated.
- R5: An internal write is issued only when int_wr_en = 1 and int_busy = 0; otherwise no port request is made and wr_refused is high for exactly one cycle.
- R6: ptr_inc adds 1 to the active bank only, wrapping from FFFFH to 0000H.
- R7: A register write to a bank in the same cycle as an increment of that bank wins: the written byte takes the new data, the other bytes keep their values, and no increment happens.
- R8: An access sampled in the same cycle as an increment uses the pointer value from before the increment.
- R9: A sampled access produces its port request (or refusal) in the next cycle for one cycle only, and at most one of int_req, ext_req and wr_refused is high at a time.
- R10: Internal reads are issued regardless of int_wr_en and int_busy.
- R11: sfr_rdata is 00H when sfr_rd is low or the address matches no pointer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_wr | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_rdata | output | 8 | Register read data (combinational) |
| bank_sel | input | SEL_W | Active pointer bank select |
| int_en | input | 1 | Route indirect accesses to internal memory |
| int_wr_en | input | 1 | Internal memory write enable |
| ptr_inc | input | 1 | Increment the active pointer |
| acc_req | input | 1 | Indirect access request |
| acc_we | input | 1 | Access is a write |
| acc_wdata | input | 8 | Access write data |
| int_busy | input | 1 | Internal memory busy |
| int_req | output | 1 | Internal memory request |
| int_we | output | 1 | Internal memory write |
| int_addr | output | IADDR_W | Internal memory address |
| int_wdata | output | 8 | Internal memory write data |
| ext_req | output | 1 | External memory request |
| ext_we | output | 1 | External memory write |
| ext_addr | output | PTR_W | External memory address |
| ext_wdata | output | 8 | External memory write data |
| wr_refused | output | 1 | One-cycle refusal of an internal write |

## Verification
The bench builds the block with its defaults: two 16-bit banks at base 82H, an 11-bit internal address and a registered port stage. With two banks, the one-bit select and the 82H to 85H decode can be checked directly. The 11-bit internal address shows that the upper pointer bits are dropped on the internal path but kept on the external one. The registered stage makes the one-cycle request timing observable. It also shows the pre-increment address being used when an access and an increment fall in the same cycle.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

   // Destination chosen for one sampled indirect access
   typedef enum logic [1:0] {
      TGT_NONE   = 2'd0,
      TGT_INT    = 2'd1,
      TGT_EXT    = 2'd2,
      TGT_REFUSE = 2'd3
   } tgt_e;

   localparam int SFR_AW = 8;
   localparam int SFR_DW = 8;

endpackage

// File: rtl/dptr_bank.sv
module dptr_bank #(
   parameter int PTR_W = 16,
   parameter int BASE  = 8'h82
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       sfr_addr,
   input  logic [7:0]       sfr_wdata,
   input  logic             sfr_wr,
   input  logic             inc,
   output logic [PTR_W-1:0] value
);
   localparam int NB = PTR_W / 8;

   logic [NB-1:0]    byte_wr;
   logic [PTR_W-1:0] nxt;

   for (genvar k = 0; k < NB; k++) begin : g_byte
      assign byte_wr[k] = sfr_wr && (sfr_addr == 8'(BASE + k));
   end

   // Register writes take precedence over the increment
   always_comb begin
      nxt = value;
      if (|byte_wr) begin
         for (int k = 0; k < NB; k++) begin
            if (byte_wr[k]) nxt[k*8 +: 8] = sfr_wdata;
         end
      end else if (inc) begin
         nxt = value + PTR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= nxt;
   end
endmodule

// File: rtl/dptr_route.sv
module dptr_route
   import dptr_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int PTR_W     = 16,
   parameter int SEL_W     = 1
) (
   input  logic [NUM_BANKS-1:0][PTR_W-1:0] bank_val,
   input  logic [SEL_W-1:0]                bank_sel,
   input  logic                            int_en,
   input  logic                            int_wr_en,
   input  logic                            int_busy,
   input  logic                            acc_req,
   input  logic                            acc_we,
   output logic [SEL_W-1:0]                act_idx,
   output logic [PTR_W-1:0]                act_ptr,
   output tgt_e                            tgt
);
   // Out-of-range selects clamp to the last bank
   always_comb begin
      if (int'(bank_sel) < NUM_BANKS) act_idx = bank_sel;
      else                            act_idx = SEL_W'(NUM_BANKS - 1);
      act_ptr = bank_val[act_idx];
   end

   always_comb begin
      if (!acc_req)                                tgt = TGT_NONE;
      else if (!int_en)                            tgt = TGT_EXT;
      else if (acc_we && (!int_wr_en || int_busy)) tgt = TGT_REFUSE;
      else                                         tgt = TGT_INT;
   end
endmodule

// File: rtl/dptr_port_stage.sv
module dptr_port_stage
   import dptr_pkg::*;
#(
   parameter int PTR_W   = 16,
   parameter int IADDR_W = 11,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  tgt_e               tgt,
   input  logic [PTR_W-1:0]   ptr,
   input  logic               we,
   input  logic [7:0]         wdata,
   output logic               int_req,
   output logic               int_we,
   output logic [IADDR_W-1:0] int_addr,
   output logic [7:0]         int_wdata,
   output logic               ext_req,
   output logic               ext_we,
   output logic [PTR_W-1:0]   ext_addr,
   output logic [7:0]         ext_wdata,
   output logic               wr_refused
);
   logic               n_ireq, n_iwe, n_ereq, n_ewe, n_ref;
   logic [IADDR_W-1:0] n_iaddr;
   logic [PTR_W-1:0]   n_eaddr;
   logic [7:0]         n_iwd, n_ewd;

   always_comb begin
      n_ireq  = (tgt == TGT_INT);
      n_ereq  = (tgt == TGT_EXT);
      n_ref   = (tgt == TGT_REFUSE);
      n_iwe   = n_ireq && we;
      n_ewe   = n_ereq && we;
      n_iaddr = n_ireq ? ptr[IADDR_W-1:0] : '0;
      n_eaddr = n_ereq ? ptr : '0;
      n_iwd   = n_iwe ? wdata : '0;
      n_ewd   = n_ewe ? wdata : '0;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            int_req    <= 1'b0;
            int_we     <= 1'b0;
            int_addr   <= '0;
            int_wdata  <= '0;
            ext_req    <= 1'b0;
            ext_we     <= 1'b0;
            ext_addr   <= '0;
            ext_wdata  <= '0;
            wr_refused <= 1'b0;
         end else begin
            int_req    <= n_ireq;
            int_we     <= n_iwe;
            int_addr   <= n_iaddr;
            int_wdata  <= n_iwd;
            ext_req    <= n_ereq;
            ext_we     <= n_ewe;
            ext_addr   <= n_eaddr;
            ext_wdata  <= n_ewd;
            wr_refused <= n_ref;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      always_comb begin
         int_req    = n_ireq;
         int_we     = n_iwe;
         int_addr   = n_iaddr;
         int_wdata  = n_iwd;
         ext_req    = n_ereq;
         ext_we     = n_ewe;
         ext_addr   = n_eaddr;
         ext_wdata  = n_ewd;
         wr_refused = n_ref;
      end
   end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
   import dptr_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int PTR_W     = 16,
   parameter int IADDR_W   = 11,
   parameter int SFR_BASE  = 8'h82,
   parameter bit OUT_REG   = 1'b1,
   localparam int NB       = PTR_W / 8,
   localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         sfr_addr,
   input  logic [7:0]         sfr_wdata,
   input  logic               sfr_wr,
   input  logic               sfr_rd,
   output logic [7:0]         sfr_rdata,
   input  logic [SEL_W-1:0]   bank_sel,
   input  logic               int_en,
   input  logic               int_wr_en,
   input  logic               ptr_inc,
   input  logic               acc_req,
   input  logic               acc_we,
   input  logic [7:0]         acc_wdata,
   input  logic               int_busy,
   output logic               int_req,
   output logic               int_we,
   output logic [IADDR_W-1:0] int_addr,
   output logic [7:0]         int_wdata,
   output logic               ext_req,
   output logic               ext_we,
   output logic [PTR_W-1:0]   ext_addr,
   output logic [7:0]         ext_wdata,
   output logic               wr_refused
);
   // Elaboration-time parameter checks
   if (PTR_W < 16 || (PTR_W % 8) != 0) begin : g_bad_w
      $error("PTR_W must be a multiple of 8, at least 16");
   end
   if (NUM_BANKS < 2) begin : g_bad_n
      $error("NUM_BANKS must be at least 2");
   end
   if (IADDR_W < 1 || IADDR_W > PTR_W) begin : g_bad_ia
      $error("IADDR_W must lie in 1..PTR_W");
   end
   if (SFR_BASE + NUM_BANKS * NB > 256) begin : g_bad_base
      $error("pointer bytes overflow the register address space");
   end

   logic [NUM_BANKS-1:0][PTR_W-1:0] bank_val;
   logic [SEL_W-1:0]                act_idx;
   logic [PTR_W-1:0]                act_ptr;
   tgt_e                            tgt;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic inc_b;
      assign inc_b = ptr_inc && (int'(act_idx) == b);
      dptr_bank #(
         .PTR_W (PTR_W),
         .BASE  (SFR_BASE + b * NB)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .sfr_addr  (sfr_addr),
         .sfr_wdata (sfr_wdata),
         .sfr_wr    (sfr_wr),
         .inc       (inc_b),
         .value     (bank_val[b])
      );
   end

   // Register readback of every pointer byte
   always_comb begin
      sfr_rdata = '0;
      if (sfr_rd) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            for (int k = 0; k < NB; k++) begin
               if (sfr_addr == 8'(SFR_BASE + b * NB + k))
                  sfr_rdata = bank_val[b][k*8 +: 8];
            end
         end
      end
   end

   dptr_route #(
      .NUM_BANKS (NUM_BANKS),
      .PTR_W     (PTR_W),
      .SEL_W     (SEL_W)
   ) u_route (
      .bank_val  (bank_val),
      .bank_sel  (bank_sel),
      .int_en    (int_en),
      .int_wr_en (int_wr_en),
      .int_busy  (int_busy),
      .acc_req   (acc_req),
      .acc_we    (acc_we),
      .act_idx   (act_idx),
      .act_ptr   (act_ptr),
      .tgt       (tgt)
   );

   dptr_port_stage #(
      .PTR_W   (PTR_W),
      .IADDR_W (IADDR_W),
      .OUT_REG (OUT_REG)
   ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .tgt        (tgt),
      .ptr        (act_ptr),
      .we         (acc_we),
      .wdata      (acc_wdata),
      .int_req    (int_req),
      .int_we     (int_we),
      .int_addr   (int_addr),
      .int_wdata  (int_wdata),
      .ext_req    (ext_req),
      .ext_we     (ext_we),
      .ext_addr   (ext_addr),
      .ext_wdata  (ext_wdata),
      .wr_refused (wr_refused)
   );
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
   parameter int NUM_BANKS = 2,
   parameter int PTR_W     = 16,
   parameter int SFR_BASE  = 8'h82,
   parameter bit OUT_REG   = 1'b1,
   parameter int SEL_W     = 1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_BANKS-1:0][PTR_W-1:0] bank_val,
   input logic [SEL_W-1:0]                bank_sel,
   input logic                            ptr_inc,
   input logic                            sfr_wr,
   input logic [7:0]                      sfr_addr,
   input logic                            int_en,
   input logic                            int_wr_en,
   input logic                            int_busy,
   input logic                            acc_req,
   input logic                            acc_we,
   input logic                            int_req,
   input logic                            int_we,
   input logic                            ext_req,
   input logic [PTR_W-1:0]                ext_addr,
   input logic                            wr_refused
);
   localparam int NB = PTR_W / 8;

   if (OUT_REG) begin : g_seq
      assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({int_req, ext_req, wr_refused}));

      assert_int_write_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (int_req && int_we) |-> $past(int_wr_en && !int_busy));

      assert_refuse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
         wr_refused |-> $past(acc_req && acc_we && int_en));

      assert_ext_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ext_req |-> $past(acc_req && !int_en));

      assert_ext_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_req && (int'($past(bank_sel)) < NUM_BANKS))
            |-> ext_addr == $past(bank_val[bank_sel]));
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      logic hit_b;
      assign hit_b = sfr_wr && (sfr_addr >= 8'(SFR_BASE + b * NB))
                            && (sfr_addr <  8'(SFR_BASE + (b + 1) * NB));

      assert_inc_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ptr_inc && int'(bank_sel) == b && !hit_b)
            |=> bank_val[b] == $past(bank_val[b]) + PTR_W'(1));

      assert_inc_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(bank_sel) != b && int'(bank_sel) < NUM_BANKS && !hit_b)
            |=> $stable(bank_val[b]));
   end
endmodule

bind dptr_unit dptr_unit_chk #(
   .NUM_BANKS (NUM_BANKS),
   .PTR_W     (PTR_W),
   .SFR_BASE  (SFR_BASE),
   .OUT_REG   (OUT_REG),
   .SEL_W     (SEL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bank_val   (bank_val),
   .bank_sel   (bank_sel),
   .ptr_inc    (ptr_inc),
   .sfr_wr     (sfr_wr),
   .sfr_addr   (sfr_addr),
   .int_en     (int_en),
   .int_wr_en  (int_wr_en),
   .int_busy   (int_busy),
   .acc_req    (acc_req),
   .acc_we     (acc_we),
   .int_req    (int_req),
   .int_we     (int_we),
   .ext_req    (ext_req),
   .ext_addr   (ext_addr),
   .wr_refused (wr_refused)
);

// File: tb/tb_dptr_unit.sv
module tb_dptr_unit;
   localparam int CLK_PERIOD = 10;

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_INC = 2'd2, OP_ACC = 2'd3;
   localparam logic [1:0] T_REF = 2'd0, T_INT = 2'd1, T_EXT = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  a;
      logic [7:0]  d;
      logic        sel;
      logic        ie;
      logic        wen;
      logic        busy;
      logic        awe;
      logic [1:0]  tgt;
      logic [15:0] exp;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{OP_RD,  8'h82, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0000, 4'd1},  // R1
      '{OP_RD,  8'h85, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0000, 4'd1},  // R1
      '{OP_WR,  8'h82, 8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0000, 4'd2},
      '{OP_WR,  8'h83, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0000, 4'd2},
      '{OP_WR,  8'h84, 8'hCD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0000, 4'd2},
      '{OP_WR,  8'h85, 8'hAB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0000, 4'd2},
      '{OP_RD,  8'h83, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0012, 4'd2},  // R2
      '{OP_RD,  8'h84, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h00CD, 4'd2},  // R2
      '{OP_ACC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_EXT, 16'h1234, 4'd3},  // R3
      '{OP_ACC, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, T_EXT, 16'hABCD, 4'd3},  // R3
      '{OP_ACC, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, T_INT, 16'h03CD, 4'd4},  // R4
      '{OP_ACC, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, T_INT, 16'h0234, 4'd5},  // R5
      '{OP_ACC, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, T_REF, 16'h0000, 4'd5},  // R5
      '{OP_ACC, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, T_REF, 16'h0000, 4'd5},  // R5
      '{OP_ACC, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, T_INT, 16'h0234, 4'd10}, // R10
      '{OP_INC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0000, 4'd6},
      '{OP_RD,  8'h82, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h0035, 4'd6},  // R6
      '{OP_RD,  8'h84, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, T_REF, 16'h00CD, 4'd6},  // R6
      '{OP_ACC, 8'h00, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, T_EXT, 16'hABCD, 4'd4}   // R4
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
   logic        sfr_wr = 1'b0, sfr_rd = 1'b0;
   logic [0:0]  bank_sel = '0;
   logic        int_en = 1'b0, int_wr_en = 1'b0, ptr_inc = 1'b0;
   logic        acc_req = 1'b0, acc_we = 1'b0, int_busy = 1'b0;
   logic [7:0]  acc_wdata = '0;
   logic        int_req, int_we, ext_req, ext_we, wr_refused;
   logic [10:0] int_addr;
   logic [7:0]  int_wdata, ext_wdata;
   logic [15:0] ext_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dptr_unit dut (
      .clk(clk), .rst_n(rst_n),
      .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
      .sfr_rdata(sfr_rdata), .bank_sel(bank_sel), .int_en(int_en), .int_wr_en(int_wr_en),
      .ptr_inc(ptr_inc), .acc_req(acc_req), .acc_we(acc_we), .acc_wdata(acc_wdata),
      .int_busy(int_busy), .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
      .int_wdata(int_wdata), .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .wr_refused(wr_refused)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic sfr_read(input string req, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      sfr_addr = a; sfr_rd = 1'b1;
      #1;
      check(req, 32'(sfr_rdata), 32'(exp));
      sfr_rd = 1'b0;
   endtask

   // Sample ports one cycle after the access, then confirm they drop (R9)
   task automatic check_access(input string req, input logic [1:0] tgt,
                               input logic [15:0] exp, input logic awe, input logic [7:0] d);
      logic [31:0] got;
      logic [31:0] want;
      got  = {ext_req, int_req, wr_refused, ext_we, int_we};
      want = {tgt == T_EXT, tgt == T_INT, tgt == T_REF,
              (tgt == T_EXT) && awe, (tgt == T_INT) && awe};
      check(req, got, want);
      if (tgt == T_INT) check(req, 32'({int_addr, int_wdata}), 32'({exp[10:0], awe ? d : 8'h00}));
      if (tgt == T_EXT) check(req, 32'({ext_addr, ext_wdata}), 32'({exp, awe ? d : 8'h00}));
      @(negedge clk);
      check("R9", 32'({ext_req, int_req, wr_refused}), 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string rs;
         rs = $sformatf("R%0d", VEC[i].rq);
         bank_sel  = VEC[i].sel;
         int_en    = VEC[i].ie;
         int_wr_en = VEC[i].wen;
         int_busy  = VEC[i].busy;
         case (VEC[i].op)
            OP_WR:  sfr_write(VEC[i].a, VEC[i].d);
            OP_RD:  sfr_read(rs, VEC[i].a, VEC[i].exp[7:0]);
            OP_INC: begin
               @(negedge clk); ptr_inc = 1'b1;
               @(negedge clk); ptr_inc = 1'b0;
            end
            default: begin
               @(negedge clk);
               acc_req = 1'b1; acc_we = VEC[i].awe; acc_wdata = VEC[i].d;
               @(negedge clk);
               acc_req = 1'b0; acc_we = 1'b0;
               check_access(rs, VEC[i].tgt, VEC[i].exp, VEC[i].awe, VEC[i].d);
            end
         endcase
      end
      int_en = 1'b0; int_wr_en = 1'b0; int_busy = 1'b0;

      // R6 wrap of bank 1, bank 0 untouched
      sfr_write(8'h84, 8'hFF);
      sfr_write(8'h85, 8'hFF);
      bank_sel = 1'b1;
      @(negedge clk); ptr_inc = 1'b1;
      @(negedge clk); ptr_inc = 1'b0;
      sfr_read("R6", 8'h84, 8'h00);
      sfr_read("R6", 8'h85, 8'h00);
      sfr_read("R6", 8'h82, 8'h35);

      // R7 register write beats increment on the same bank
      bank_sel = 1'b0;
      @(negedge clk);
      sfr_addr = 8'h82; sfr_wdata = 8'h10; sfr_wr = 1'b1; ptr_inc = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0; ptr_inc = 1'b0;
      sfr_read("R7", 8'h82, 8'h10);
      sfr_read("R7", 8'h83, 8'h12);

      // R8 access and increment in one cycle use the old pointer
      @(negedge clk);
      acc_req = 1'b1; ptr_inc = 1'b1;
      @(negedge clk);
      acc_req = 1'b0; ptr_inc = 1'b0;
      check_access("R8", T_EXT, 16'h1210, 1'b0, 8'h00);
      sfr_read("R8", 8'h82, 8'h11);

      // R11 unmatched address and idle read strobe give zero
      sfr_read("R11", 8'h86, 8'h00);
      sfr_read("R11", 8'h81, 8'h00);
      @(negedge clk);
      sfr_addr = 8'h82; sfr_rd = 1'b0;
      #1 check("R11", 32'(sfr_rdata), 32'h0);

      // R1 reset returns both banks to zero
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      sfr_read("R1", 8'h82, 8'h00);
      sfr_read("R1", 8'h83, 8'h00);
      sfr_read("R1", 8'h84, 8'h00);
      #1 check("R1", 32'({int_req, ext_req, wr_refused}), 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule